// File: doc/BRIEF.md
# Four-Channel Timer Input Capture Unit

This block timestamps signal transitions on four input pins against one shared 16-bit free-running counter. Each channel passes its pin through a two-flop synchronizer, looks for the edge kind chosen for it, and copies the counter into its own capture register when that edge arrives. It also raises a per-channel capture flag that software clears. The counter advances on the rising clock edge and the capture registers load on the falling edge, so a captured value is never taken while the counter is changing.

The fourth channel shares its register and pin with a compare function. A mode bit chooses the role. In compare role, the register is a plain writable compare value and the channel never captures. In capture role, the register is read-only. The shared pin can also be turned into an output driven from a register bit. In that case the channel watches the driven value, so a write to that bit can cause a capture.

Software reaches everything through an 8-bit register bus with a 4-bit address. Each 16-bit capture register is read as two bytes. Reading the high byte freezes the low byte in a buffer, so a high-then-low read pair always gives one coherent timestamp.

Top module: `icap_unit`

## Requirements
- R1: Reset clears the edge-select register (address 0), the shared-channel mode register (address 1) and the flag register (address 2). The counter restarts at 0 and adds one on every clock while reset is low, wrapping at 16 bits.
- R2: Each channel has a 2-bit edge code: 00 ignores the pin, 01 captures rising edges only, 10 captures falling edges only, and 11 captures both.
- R3: The edge-select register at address 0 holds the codes, highest bits first: channel 4 in bits 7:6, channel 1 in bits 5:4, channel 2 in bits 3:2 and channel 3 in bits 1:0. In each field the upper bit is the more significant bit of the code.
- R4: A pin transition is qualifying if its edge code selects it. A qualifying transition that happens after a rising clock edge captures a counter value two greater than the count just after that edge. The full 16 bits load at once.
- R5: Channels whose qualifying edges are detected in the same clock cycle capture identical values.
- R6: Capture registers keep their contents through reset.
- R7: Channel n (1..4) reads its high byte at address 6+2n and its low byte at address 7+2n. Reading the high byte latches the low byte into a buffer, and the low address returns that buffer. A capture between the two reads does not change the low byte returned.
- R8: A capture sets flag bit n-1 at address 2 on the clock after detection. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: Mode register bit 0 selects capture role for channel 4. While it is 0, channel 4 never captures or flags, and byte writes to addresses 14 and 15 load the shared register.
- R10: While mode bit 0 is 1, writes to addresses 14 and 15 leave the shared register unchanged.
- R11: Mode register bit 1 makes the shared pin an output (pin4_oe_o = 1) that drives mode bit 2 on pin4_out_o. Channel 4 then watches bit 2 instead of the external pin. A bus write that flips bit 2 captures a count three greater than the count seen during the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counter on rising edge, captures on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin_i | input | 4 | Capture inputs, bit n-1 for channel n |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Write strobe, taken at the rising edge ending the cycle |
| bus_rd_i | input | 1 | Read strobe, used for the high-byte latch side effect |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address |
| pin4_oe_o | output | 1 | Output enable for the shared channel-4 pin |
| pin4_out_o | output | 1 | Value driven on the shared channel-4 pin |

## Verification
A synchronizer or edge decoder fault shows up as a flag that is missing, appears on the wrong channel, or appears for the wrong polarity, four clocks after the pin change. A counter or phase fault shows up as a captured value that is off by one or more counts, seen on the next read pair. A broken byte buffer or shared-register gating shows up as a mismatched low byte, or as a compare value that changes when it should not. Random edge codes and pin patterns are checked against a counter model kept in the bench, and directed cases cover the shared-pin roles.

// File: rtl/icap_pkg.sv
package icap_pkg;

    localparam int NCH    = 4;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic pin_lvl;
        logic pin_dir;
        logic cap4_on;
    } shr_ctl_t;

    localparam logic [ADDR_W-1:0] ADR_EDGE = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 4'd2;

    // Bit position of a channel's edge field; channel index 0 is channel 1.
    function automatic int unsigned field_lsb(int unsigned ch);
        return (ch == NCH - 1) ? 6 : 4 - 2 * ch;
    endfunction

    // Address of a capture byte; high byte at even, low at odd.
    function automatic logic [ADDR_W-1:0] cap_addr(int unsigned ch, logic lo);
        return ADDR_W'(8 + 2 * ch) | {{(ADDR_W-1){1'b0}}, lo};
    endfunction

    function automatic logic edge_hit(edge_sel_e sel, logic now_lv, logic old_lv);
        case (sel)
            EDGE_RISE: return now_lv & ~old_lv;
            EDGE_FALL: return ~now_lv & old_lv;
            EDGE_ANY:  return now_lv ^ old_lv;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/icap_counter.sv
module icap_counter
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output cnt_t cnt_o
);

    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R1

endmodule

// File: rtl/icap_edge_chan.sv
module icap_edge_chan
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  edge_sel_e sel_i,
    input  logic      en_i,
    output logic      hit_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            old_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            old_q  <= sync_q[SYNC_STAGES-1];
        end
    end

    assign hit_o = en_i && edge_hit(sel_i, sync_q[SYNC_STAGES-1], old_q);

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        sel_i == EDGE_OFF |-> !hit_o); // R2

endmodule

// File: rtl/icap_capture_bank.sv
module icap_capture_bank
    import icap_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  cnt_t                          cnt_i,
    input  logic [NCH-1:0]                hit_i,
    input  logic                          shr_wr_ok_i,
    input  logic                          wr_hi_i,
    input  logic                          wr_lo_i,
    input  logic [BYTE_W-1:0]             wdata_i,
    input  logic [NCH-1:0]                rd_hi_i,
    output logic [NCH-1:0][CNT_W-1:0]     cap_o,
    output logic [NCH-1:0][BYTE_W-1:0]    lo_buf_o
);

    localparam int LAST = NCH - 1;

    logic [NCH-1:0][CNT_W-1:0]  cap_q;
    logic [NCH-1:0][BYTE_W-1:0] lo_q;

    // Falling-edge load: the counter settled at the previous rising edge.
    always_ff @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (hit_i[i]) cap_q[i] <= cnt_i;
        end
        if (shr_wr_ok_i && !hit_i[LAST]) begin
            if (wr_hi_i) cap_q[LAST][CNT_W-1 -: BYTE_W] <= wdata_i;
            if (wr_lo_i) cap_q[LAST][BYTE_W-1:0]        <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rd_hi_i[i]) lo_q[i] <= cap_q[i][BYTE_W-1:0];
        end
    end

    assign cap_o    = cap_q;
    assign lo_buf_o = lo_q;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            AST_CAP_TAKES_COUNT: assert property (@(posedge clk) disable iff (rst)
                hit_i[g] |-> cap_q[g] == cnt_i); // R4
        end
    endgenerate

    AST_SAME_COUNT: assert property (@(posedge clk) disable iff (rst)
        hit_i[0] && hit_i[1] |-> cap_q[0] == cap_q[1]); // R5

    AST_SHR_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !shr_wr_ok_i && !hit_i[LAST] |-> $stable(cap_q[LAST])); // R10

endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    cap_pin_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              pin4_oe_o,
    output logic              pin4_out_o
);

    localparam int LAST = NCH - 1;

    logic [BYTE_W-1:0]          edge_q;
    shr_ctl_t                   mode_q;
    logic [NCH-1:0]             flag_q;
    cnt_t                       cnt;
    logic [NCH-1:0]             hit;
    logic [NCH-1:0]             rd_hi;
    logic [NCH-1:0][CNT_W-1:0]  cap;
    logic [NCH-1:0][BYTE_W-1:0] lo_buf;
    logic                       wr_hi, wr_lo;

    // Control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= '0;
            mode_q <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr_i && bus_addr_i == ADR_EDGE) edge_q <= bus_wdata_i;
            if (bus_wr_i && bus_addr_i == ADR_MODE) mode_q <= shr_ctl_t'(bus_wdata_i[$bits(shr_ctl_t)-1:0]);
            if (bus_wr_i && bus_addr_i == ADR_FLAG)
                flag_q <= (flag_q & ~bus_wdata_i[NCH-1:0]) | hit;
            else
                flag_q <= flag_q | hit;
        end
    end

    icap_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            logic pin_src;
            logic ch_en;
            if (g == LAST) begin : g_shared
                assign pin_src = mode_q.pin_dir ? mode_q.pin_lvl : cap_pin_i[g];
                assign ch_en   = mode_q.cap4_on;
            end else begin : g_plain
                assign pin_src = cap_pin_i[g];
                assign ch_en   = 1'b1;
            end

            icap_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk   (clk),
                .rst   (rst),
                .pin_i (pin_src),
                .sel_i (edge_sel_e'(edge_q[field_lsb(g) +: 2])),
                .en_i  (ch_en),
                .hit_o (hit[g])
            );

            assign rd_hi[g] = bus_rd_i && (bus_addr_i == cap_addr(g, 1'b0));

            AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
                hit[g] |=> flag_q[g]); // R8
        end
    endgenerate

    assign wr_hi = bus_wr_i && (bus_addr_i == cap_addr(LAST, 1'b0));
    assign wr_lo = bus_wr_i && (bus_addr_i == cap_addr(LAST, 1'b1));

    icap_capture_bank u_bank (
        .clk         (clk),
        .rst         (rst),
        .cnt_i       (cnt),
        .hit_i       (hit),
        .shr_wr_ok_i (!mode_q.cap4_on),
        .wr_hi_i     (wr_hi),
        .wr_lo_i     (wr_lo),
        .wdata_i     (bus_wdata_i),
        .rd_hi_i     (rd_hi),
        .cap_o       (cap),
        .lo_buf_o    (lo_buf)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i[ADDR_W-1]) begin
            if (bus_addr_i[0]) bus_rdata_o = lo_buf[bus_addr_i[2:1]];
            else               bus_rdata_o = cap[bus_addr_i[2:1]][CNT_W-1 -: BYTE_W];
        end else begin
            case (bus_addr_i)
                ADR_EDGE: bus_rdata_o = edge_q;
                ADR_MODE: bus_rdata_o = BYTE_W'(mode_q);
                ADR_FLAG: bus_rdata_o = BYTE_W'(flag_q);
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign pin4_oe_o  = mode_q.pin_dir;
    assign pin4_out_o = mode_q.pin_lvl;

    AST_CH4_IDLE_IN_OC: assert property (@(posedge clk) disable iff (rst)
        !mode_q.cap4_on |-> !hit[LAST]); // R9

endmodule

// File: tb/icap_unit_tb.sv
module icap_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pins = 4'h0;
    logic [3:0] addr = 4'h0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       oe, pout;

    int checks = 0, errors = 0;
    bit done = 0;
    int unsigned mcnt = 0;
    logic [7:0]  m_ctl = 8'h00;
    logic [2:0]  m_mode = 3'b000;
    logic [15:0] mcap [4];
    bit          mval [4];
    logic [3:0]  mflag = 4'h0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) mcnt <= 0;
        else     mcnt <= mcnt + 1;
    end

    icap_unit u_dut (
        .clk(clk), .rst(rst), .cap_pin_i(pins), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .pin4_oe_o(oe), .pin4_out_o(pout)
    );

    function automatic int lsb_of(int ch);
        case (ch)
            0: return 4;
            1: return 2;
            2: return 0;
            default: return 6;
        endcase
    endfunction

    function automatic bit qualifies(logic [1:0] code, logic o, logic n);
        case (code)
            2'b01: return !o && n;
            2'b10: return o && !n;
            2'b11: return o != n;
            default: return 0;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
        if (a == 4'd0) m_ctl = d;
        if (a == 4'd1) m_mode = d[2:0];
    endtask

    task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #6 d = rdata;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic rd_cap(int ch, output logic [15:0] v);
        logic [7:0] h, l;
        rd_reg(4'(8 + 2 * ch), h);
        rd_reg(4'(9 + 2 * ch), l);
        v = {h, l};
    endtask

    // External pin change; channel 4 only sees it in capture role with input direction.
    task automatic drive_pins(logic [3:0] nv);
        for (int ch = 0; ch < 4; ch++) begin
            bit live = (ch < 3) || (m_mode[0] && !m_mode[1]);
            if (live && qualifies(m_ctl[lsb_of(ch) +: 2], pins[ch], nv[ch])) begin
                mcap[ch] = 16'(mcnt + 2);
                mval[ch] = 1;
                mflag[ch] = 1'b1;
            end
        end
        pins = nv;
        repeat (4) tick();
    endtask

    task automatic check_all(string req);
        logic [15:0] v;
        logic [7:0]  f;
        for (int ch = 0; ch < 4; ch++) begin
            if (mval[ch]) begin
                rd_cap(ch, v);
                check(req, v, mcap[ch]);
            end
        end
        rd_reg(4'd2, f);
        check("R8 flags", f, {4'h0, mflag});
        wr_reg(4'd2, 8'h0F);
        mflag = 4'h0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] v, held;
        logic [3:0]  np;
        for (int i = 0; i < 4; i++) mval[i] = 0;
        void'($urandom(32'h1CE5));
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        rd_reg(4'd0, d); check("R1 edge reg", d, 8'h00);
        rd_reg(4'd1, d); check("R1 mode reg", d, 8'h00);
        rd_reg(4'd2, d); check("R1 flag reg", d, 8'h00);
        check("R1 oe", oe, 1'b0);

        // R3 layout: only channel 2 rising (bits 3:2 = 01)
        wr_reg(4'd1, 8'h01);
        wr_reg(4'd0, 8'h04);
        drive_pins(4'hF);
        rd_reg(4'd2, d); check("R3 only ch2 flag", d, 8'h02);
        wr_reg(4'd2, 8'h0F); mflag = 0;
        drive_pins(4'h0);

        // R4/R5: all channels any edge, same-cycle edges
        wr_reg(4'd0, 8'hFF);
        v = 16'(mcnt + 2);
        drive_pins(4'hF);
        for (int ch = 0; ch < 4; ch++) begin
            rd_cap(ch, held);
            check("R5 same count", held, v);
        end
        check_all("R4 capture value");

        // R7 coherent byte pair
        drive_pins(4'hE);
        held = mcap[0];
        rd_reg(4'd8, d);
        drive_pins(4'hF);
        rd_reg(4'd9, wdata);
        check("R7 coherent pair", {d, wdata}, held);
        check_all("R7 new value");

        // R8 write-1-clear touches only written bits
        drive_pins(4'h0);
        wr_reg(4'd2, 8'h05);
        rd_reg(4'd2, d); check("R8 partial clear", d, 8'h0A);
        wr_reg(4'd2, 8'h0F); mflag = 0;

        // R6 capture registers survive reset
        rst = 1'b1; repeat (2) tick(); rst = 1'b0;
        m_ctl = 0; m_mode = 0;
        rd_cap(0, v); check("R6 retained ch1", v, mcap[0]);
        rd_cap(1, v); check("R6 retained ch2", v, mcap[1]);

        // R9 compare role: no capture, register writable
        wr_reg(4'd0, 8'hC0);
        drive_pins(4'h8);
        rd_reg(4'd2, d); check("R9 no ch4 flag", d, 8'h00);
        wr_reg(4'd14, 8'hAB);
        wr_reg(4'd15, 8'hCD);
        rd_cap(3, v); check("R9 compare write", v, 16'hABCD);

        // R10 capture role: writes ignored
        wr_reg(4'd1, 8'h01);
        rd_reg(4'd1, d); check("R10 mode readback", d, 8'h01);
        wr_reg(4'd14, 8'h11);
        wr_reg(4'd15, 8'h22);
        rd_cap(3, v); check("R10 write ignored", v, 16'hABCD);
        mcap[3] = 16'hABCD; mval[3] = 1;

        // R2 random edge codes and pin patterns
        for (int it = 0; it < 30; it++) begin
            wr_reg(4'd0, 8'($urandom));
            np = 4'($urandom);
            drive_pins(np);
            check_all("R2 random capture");
        end

        // R11 shared pin as output, captures from its own data writes
        wr_reg(4'd0, 8'hC0);
        drive_pins(4'h0);
        check_all("R11 setup");
        wr_reg(4'd1, 8'h03);
        v = 16'(mcnt + 3);
        wr_reg(4'd1, 8'h07);
        repeat (4) tick();
        check("R11 oe", oe, 1'b1);
        check("R11 out", pout, 1'b1);
        rd_cap(3, held); check("R11 capture from write", held, v);
        rd_reg(4'd2, d); check("R11 flag", d, 8'h08);
        wr_reg(4'd2, 8'h0F);
        pins = 4'h8; repeat (4) tick();
        rd_reg(4'd2, d); check("R11 external pin ignored", d, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule